// File: doc/BRIEF.md
# Modem Status Change Detector

This block keeps the modem status byte of a 16550-style serial port. Four modem lines are sampled every clock: clear-to-send, data-set-ready, carrier detect and ring indicator. In normal operation they come from the external pins through a synchroniser. In loopback mode they come from the four modem control outputs instead. The upper nibble of the byte holds the current line levels. The lower nibble holds sticky change flags that record what happened since the last read.

Software reads the byte by pulsing a read strobe. The value on `status_q` during the strobe cycle is the value returned. The change flags are cleared at the edge that ends that cycle, unless a new change arrives in the same cycle. Any set change flag raises an interrupt request when the modem-status interrupt enable is high.

Top module: `modem_status_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `status_q` becomes 0x00 and `irq_req` is low after that edge.
- R2: Bit 0 (CTS change), bit 1 (DSR change) and bit 3 (DCD change) set whenever a line's newly sampled level differs from the level stored in bits 4, 5 and 7.
- R3: Bit 2 (ring change) sets only when the sampled ring level falls from 1 to 0. A rise from 0 to 1 leaves it unchanged.
- R4: Without a read strobe, a set change bit stays set on every later clock edge.
- R5: Bits 4 (CTS), 5 (DSR), 6 (RI) and 7 (DCD) follow the sampled line levels. A level driven on a pin appears in `status_q` after the third rising edge: two synchroniser stages, then the status register.
- R6: While `loop_en` is high, the sampled levels are taken from the control bits: RTS feeds CTS, DTR feeds DSR, OUT1 feeds RI and OUT2 feeds DCD. A control level appears in `status_q` after one edge.
- R7: During a cycle with `rd_stb` high, `status_q` shows the full value being read. After that edge, all four change bits are 0 if no new change was detected in that cycle.
- R8: A change detected in the same cycle as a read strobe leaves its change bit set after the edge.
- R9: `irq_req` is high exactly when `irq_en` is high and at least one of bits 0 to 3 of `status_q` is set. It follows `irq_en` within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cts_pin | input | 1 | External clear-to-send line |
| dsr_pin | input | 1 | External data-set-ready line |
| dcd_pin | input | 1 | External carrier-detect line |
| ri_pin | input | 1 | External ring-indicator line |
| loop_en | input | 1 | Selects control bits as the line source |
| rts_ctl | input | 1 | RTS control bit (loopback source for CTS) |
| dtr_ctl | input | 1 | DTR control bit (loopback source for DSR) |
| out1_ctl | input | 1 | OUT1 control bit (loopback source for RI) |
| out2_ctl | input | 1 | OUT2 control bit (loopback source for DCD) |
| rd_stb | input | 1 | Read strobe; clears change bits at the edge |
| irq_en | input | 1 | Modem-status interrupt enable |
| status_q | output | 8 | Status byte: change flags [3:0], levels [7:4] |
| irq_req | output | 1 | Modem-status interrupt request |

## Verification
The stored line levels are visible in the upper nibble one edge after they are sampled. A corrupted level therefore shows at the port at once. It then produces a false change flag, or hides a real one, at the next sample.

A change flag that is lost, cleared too early, or set on the wrong ring edge shows in the lower nibble and in `irq_req` at the first edge after the event. The bench compares every cycle, so such a fault is reported within one clock of when it occurs.

// File: rtl/msr_pkg.sv
package msr_pkg;

    localparam int LINE_COUNT = 4;

    // Packed order gives the byte layout: dcd at the top, cts at the bottom.
    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } lines_t;

    typedef struct packed {
        lines_t level;
        lines_t change;
    } status_t;

    // Ring flags only its trailing edge; the other lines flag any toggle.
    function automatic lines_t detect_change(lines_t prev, lines_t now);
        lines_t d;
        d.cts = prev.cts ^ now.cts;
        d.dsr = prev.dsr ^ now.dsr;
        d.dcd = prev.dcd ^ now.dcd;
        d.ri  = prev.ri & ~now.ri;
        return d;
    endfunction

    function automatic lines_t loop_map(logic rts, logic dtr, logic out1, logic out2);
        lines_t m;
        m.cts = rts;
        m.dsr = dtr;
        m.ri  = out1;
        m.dcd = out2;
        return m;
    endfunction

endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/msr_src_sel.sv
module msr_src_sel
    import msr_pkg::*;
(
    input  logic   loop_en,
    input  lines_t pin_lines,
    input  lines_t ctl_lines,
    output lines_t cur_lines
);
    always_comb begin
        cur_lines = loop_en ? ctl_lines : pin_lines;
    end
endmodule

// File: rtl/msr_delta.sv
module msr_delta
    import msr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  lines_t  cur_lines,
    input  logic    rd_stb,
    output status_t stat_q
);
    lines_t fresh;

    always_comb begin
        fresh = detect_change(stat_q.level, cur_lines);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else begin
            stat_q.level  <= cur_lines;
            stat_q.change <= (rd_stb ? lines_t'('0) : stat_q.change) | fresh;
        end
    end

    // R4: change bits never drop without a read
    p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> ((stat_q.change & $past(stat_q.change)) == $past(stat_q.change)));

    // R3: ring rising edge never sets its flag
    p_ri_rise_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (!stat_q.level.ri && cur_lines.ri && (rd_stb || !stat_q.change.ri)) |=> !stat_q.change.ri);

    // R7: a read with no new activity leaves no change bits
    p_read_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && (cur_lines == stat_q.level)) |=> (stat_q.change == '0));

    // R8: CTS toggle coinciding with a read is kept
    p_keep_event_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && (cur_lines.cts != stat_q.level.cts)) |=> stat_q.change.cts);
endmodule

// File: rtl/modem_status_unit.sv
module modem_status_unit
    import msr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cts_pin,
    input  logic       dsr_pin,
    input  logic       dcd_pin,
    input  logic       ri_pin,
    input  logic       loop_en,
    input  logic       rts_ctl,
    input  logic       dtr_ctl,
    input  logic       out1_ctl,
    input  logic       out2_ctl,
    input  logic       rd_stb,
    input  logic       irq_en,
    output logic [7:0] status_q,
    output logic       irq_req
);
    lines_t  raw_pins;
    lines_t  synced;
    lines_t  ctl_lines;
    lines_t  cur_lines;
    status_t stat;

    always_comb begin
        raw_pins.cts = cts_pin;
        raw_pins.dsr = dsr_pin;
        raw_pins.dcd = dcd_pin;
        raw_pins.ri  = ri_pin;
        ctl_lines    = loop_map(rts_ctl, dtr_ctl, out1_ctl, out2_ctl);
    end

    msr_sync #(.STAGES(SYNC_STAGES), .WIDTH(LINE_COUNT)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_pins),
        .dout (synced)
    );

    msr_src_sel u_sel (
        .loop_en   (loop_en),
        .pin_lines (synced),
        .ctl_lines (ctl_lines),
        .cur_lines (cur_lines)
    );

    msr_delta u_delta (
        .clk       (clk),
        .rst       (rst),
        .cur_lines (cur_lines),
        .rd_stb    (rd_stb),
        .stat_q    (stat)
    );

    assign status_q = stat;
    assign irq_req  = irq_en && (stat.change != '0);

    // R1: reset clears the byte
    p_reset_r1: assert property (@(posedge clk) rst |=> (status_q == 8'h00));

    // R6: loopback levels track the control bits one edge later
    p_loop_map_r6: assert property (@(posedge clk) disable iff (rst)
        loop_en |=> (status_q[7:4] == $past({out2_ctl, out1_ctl, dtr_ctl, rts_ctl})));

    // R9: no request without enable and pending change
    p_irq_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        ((status_q[3:0] == 4'h0) || !irq_en) |-> !irq_req);
endmodule

// File: tb/test_modem_status_unit.sv
`timescale 1ns/1ps
module test_modem_status_unit;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cts_pin = 0, dsr_pin = 0, dcd_pin = 0, ri_pin = 0;
    logic loop_en = 0, rts_ctl = 0, dtr_ctl = 0, out1_ctl = 0, out2_ctl = 0;
    logic rd_stb = 0, irq_en = 0;
    logic [7:0] status_q;
    logic irq_req;

    always #2 clk = ~clk;

    modem_status_unit i_modem_status_unit (
        .clk(clk), .rst(rst),
        .cts_pin(cts_pin), .dsr_pin(dsr_pin), .dcd_pin(dcd_pin), .ri_pin(ri_pin),
        .loop_en(loop_en), .rts_ctl(rts_ctl), .dtr_ctl(dtr_ctl),
        .out1_ctl(out1_ctl), .out2_ctl(out2_ctl),
        .rd_stb(rd_stb), .irq_en(irq_en),
        .status_q(status_q), .irq_req(irq_req)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic [8:0] exp_q[$];
    string      tag_q[$];

    // Bench reference state, lines as {dcd,ri,dsr,cts}
    logic [3:0] m_s1 = 0, m_s2 = 0, m_lvl = 0, m_chg = 0;

    // One cycle: drive at the falling edge, predict the post-edge state.
    task automatic step(input logic r, input logic [3:0] pins, input logic lp,
                        input logic [3:0] ctl, input logic rd, input logic en,
                        input string tag);
        logic [3:0] cur, nd;
        @(negedge clk);
        rst = r;
        {dcd_pin, ri_pin, dsr_pin, cts_pin} = pins;
        loop_en = lp;
        {out2_ctl, out1_ctl, dtr_ctl, rts_ctl} = ctl;
        rd_stb = rd;
        irq_en = en;
        if (r) begin
            m_s1 = 0; m_s2 = 0; m_lvl = 0; m_chg = 0;
        end else begin
            cur = lp ? ctl : m_s2;
            nd[0] = m_lvl[0] ^ cur[0];
            nd[1] = m_lvl[1] ^ cur[1];
            nd[3] = m_lvl[3] ^ cur[3];
            nd[2] = m_lvl[2] & ~cur[2];
            m_chg = (rd ? 4'h0 : m_chg) | nd;
            m_lvl = cur;
            m_s2  = m_s1;
            m_s1  = pins;
        end
        exp_q.push_back({en & (m_chg != 0), m_lvl, m_chg});
        tag_q.push_back(tag);
    endtask

    // Monitor: pop one prediction per rising edge and compare.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [8:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_cmp++;
                if ({irq_req, status_q} !== e) begin
                    n_bad++;
                    $display("FAIL %s: got irq=%b status=%h, expected irq=%b status=%h",
                             t, irq_req, status_q, e[8], e[7:0]);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) step(1, 4'h0, 0, 4'h0, 0, 1, "R1");
        repeat (3) step(0, 4'h0, 0, 4'h0, 0, 1, "R1");
        // R2/R5 CTS rise through the synchroniser, R9 irq enabled
        step(0, 4'b0001, 0, 4'h0, 0, 1, "R5");
        repeat (4) step(0, 4'b0001, 0, 4'h0, 0, 1, "R2");
        // R7 read clears; R4 sticky was held above
        step(0, 4'b0001, 0, 4'h0, 1, 1, "R7");
        repeat (2) step(0, 4'b0001, 0, 4'h0, 0, 1, "R7");
        // R2 DSR and DCD together, irq disabled (R9)
        step(0, 4'b1011, 0, 4'h0, 0, 0, "R2");
        repeat (4) step(0, 4'b1011, 0, 4'h0, 0, 0, "R9");
        step(0, 4'b1011, 0, 4'h0, 0, 1, "R9");
        step(0, 4'b1011, 0, 4'h0, 1, 1, "R7");
        repeat (3) step(0, 4'b1011, 0, 4'h0, 0, 1, "R7");
        // R3 ring rise: no flag
        step(0, 4'b1111, 0, 4'h0, 0, 1, "R3");
        repeat (4) step(0, 4'b1111, 0, 4'h0, 0, 1, "R3");
        // R3 ring fall: flag, then R4 sticky over many cycles
        step(0, 4'b1011, 0, 4'h0, 0, 1, "R3");
        repeat (8) step(0, 4'b1011, 0, 4'h0, 0, 1, "R4");
        step(0, 4'b1011, 0, 4'h0, 1, 1, "R7");
        repeat (2) step(0, 4'b1011, 0, 4'h0, 0, 1, "R7");
        // R6 loopback: pins ignored, control bits mapped
        step(0, 4'b1011, 1, 4'b0000, 0, 1, "R6");
        step(0, 4'b0000, 1, 4'b0000, 1, 1, "R6");
        step(0, 4'b1111, 1, 4'b0101, 0, 1, "R6");
        step(0, 4'b0000, 1, 4'b0101, 1, 1, "R6");
        step(0, 4'b0000, 1, 4'b0100, 0, 1, "R3");
        step(0, 4'b0000, 1, 4'b0100, 1, 1, "R7");
        // R8 change coinciding with read
        step(0, 4'b0000, 1, 4'b1010, 1, 1, "R8");
        step(0, 4'b0000, 1, 4'b1010, 0, 1, "R8");
        step(0, 4'b0000, 1, 4'b1010, 1, 1, "R8");
        step(0, 4'b0000, 1, 4'b1011, 1, 1, "R8");
        step(0, 4'b0000, 1, 4'b1011, 0, 1, "R8");
        // Back to pins, then reset mid-activity (R1)
        repeat (4) step(0, 4'b0110, 0, 4'h0, 0, 1, "R5");
        step(1, 4'b0110, 0, 4'h0, 0, 1, "R1");
        step(0, 4'b0000, 0, 4'h0, 0, 1, "R1");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule